// File: doc/BRIEF.md
# Exception Frame Stacking and Tail-Chain Sequencer

This block moves a processor core into and out of exception handlers. When an exception is accepted, the block saves eight caller-context words to the stack through a single-beat memory port. It then reads the handler address from a vector table indexed by the exception number, waits a fixed pipeline-refill period, and presents that address as a one-cycle branch target. The frame is saved entirely in hardware, so handler code needs no extra save or restore code.

When the handler returns, there are two cases. If no other exception is waiting, the block reads the eight words back, restores the stack pointer and signals completion with the saved program counter as the return target. If another exception is pending, the block tail-chains: it leaves the frame where it is, skips the stack traffic entirely, and fetches the next handler's vector. Choosing which exception is pending, instruction execution and the register file all belong to other blocks.

Top module: `exc_frame_seq`

## Requirements
- R1: After reset the block is idle:
  - `busy`, `in_handler`, `mem_valid`, `branch_valid` and `ret_done` are 0.
  - `sp_out` is 0.
- R2: An `entry_req` seen while idle is accepted, and `ctx_in` must be held stable until the branch.
  - `ctx_in` packs word k at bits [32k+31:32k], with k = 0..7 for R0, R1, R2, R3, R12, LR, PC and the status word.
  - The block then makes exactly eight writes: word 7 goes to `sp_in`-4, word 6 to `sp_in`-8, and so on down to word 0 at `sp_in`-32.
  - `sp_out` becomes `sp_in`-32.
- R3: After the eighth write, the block makes exactly one read, at `vec_base` + 4 × exception number.
- R4: With `mem_ready` held high, `branch_valid` pulses for one cycle exactly 12 cycles after the accepting edge. `branch_pc` then equals the data returned by the vector read.
- R5: While `mem_ready` is low, the block holds `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` unchanged. Each low cycle delays the remaining sequence by one cycle.
- R6: A `ret_req` in the handler with `pend_valid` high starts a tail-chain.
  - The block makes no stack access and reads only the vector of `pend_num`.
  - `branch_valid` pulses 6 cycles after the return edge.
  - `sp_out` is unchanged.
- R7: A `ret_req` in the handler with `pend_valid` low starts a full exit.
  - The block reads the eight words at ascending addresses from `sp_out` and places word k on `rest_ctx` bits [32k+31:32k].
  - `ret_done` pulses for one cycle 8 cycles after the return edge, with `ret_pc` equal to word 6.
  - `sp_out` is then 32 higher, and the block returns to idle.
- R8: Some requests are ignored:
  - An `entry_req` while busy causes no memory access, and the block stays in the handler.
  - A `ret_req` while idle causes no memory access, and the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| entry_req | input | 1 | Accepted exception to enter (taken when idle) |
| entry_num | input | 6 | Exception number for entry |
| sp_in | input | 32 | Stack pointer at entry |
| vec_base | input | 32 | Vector table base address |
| ctx_in | input | 256 | Eight context words to save |
| ret_req | input | 1 | Handler-return strobe |
| pend_valid | input | 1 | Another exception is pending at return |
| pend_num | input | 6 | Number of the pending exception |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| branch_valid | output | 1 | One-cycle handler branch strobe |
| branch_pc | output | 32 | Handler address |
| ret_done | output | 1 | One-cycle exit-complete strobe |
| ret_pc | output | 32 | Restored program counter |
| rest_ctx | output | 256 | Restored context words |
| sp_out | output | 32 | Current stack pointer |
| busy | output | 1 | Sequencer not idle |
| in_handler | output | 1 | Handler is running |

## Verification
The bench checks the stack addresses and the data order of every beat, because a frame written in ascending order or with words swapped would be restored into the wrong registers. It stalls vector reads, stack reads and the first stack write, then checks that the latency grows by exactly the stall count. A design that dropped or duplicated a beat under back-pressure would show up as a changed beat count or a latency error.

Tail-chain scenarios check three things:
- No stack traffic occurs.
- The 6-cycle timing holds.
- The stack pointer is unchanged.

This catches a design that pops and re-pushes, or that reads the old exception's vector. The bench also sends entry requests during a handler and return requests while idle, to catch a design that restarts or corrupts its state on them.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
    localparam int FRAME_WORDS = 8;
    localparam int PC_SLOT     = 6;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PUSH,
        S_VEC,
        S_TAIL,
        S_REFILL,
        S_ENTER,
        S_HANDLER,
        S_POP,
        S_DONE
    } seq_state_e;
endpackage

// File: rtl/exc_word_sel.sv
module exc_word_sel #(
    parameter int DW = 32,
    parameter int NW = 8
) (
    input  logic [NW*DW-1:0]      words_i,
    input  logic [$clog2(NW)-1:0] sel_i,
    output logic [DW-1:0]         word_o
);
    logic [DW-1:0] slot [NW];

    for (genvar g = 0; g < NW; g++) begin : g_slot
        assign slot[g] = words_i[g*DW +: DW];
    end

    assign word_o = slot[sel_i];
endmodule

// File: rtl/exc_pop_store.sv
module exc_pop_store #(
    parameter int DW = 32,
    parameter int NW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_i,
    input  logic [$clog2(NW)-1:0] sel_i,
    input  logic [DW-1:0]         din_i,
    output logic [NW*DW-1:0]      words_o
);
    localparam int SW = $clog2(NW);

    for (genvar g = 0; g < NW; g++) begin : g_word
        logic [DW-1:0] w_d, w_q;

        always_comb begin
            w_d = w_q;
            if (load_i && sel_i == SW'(g)) begin
                w_d = din_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                w_q <= '0;
            end else begin
                w_q <= w_d;
            end
        end

        assign words_o[g*DW +: DW] = w_q;
    end
endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
    import exc_seq_pkg::*;
#(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int NUM_W      = 6,
    parameter int REFILL_CYC = 3,
    parameter int TAIL_GAP   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      entry_req,
    input  logic [NUM_W-1:0]          entry_num,
    input  logic [AW-1:0]             sp_in,
    input  logic [AW-1:0]             vec_base,
    input  logic [FRAME_WORDS*DW-1:0] ctx_in,
    input  logic                      ret_req,
    input  logic                      pend_valid,
    input  logic [NUM_W-1:0]          pend_num,
    output logic                      mem_valid,
    output logic                      mem_we,
    output logic [AW-1:0]             mem_addr,
    output logic [DW-1:0]             mem_wdata,
    input  logic                      mem_ready,
    input  logic [DW-1:0]             mem_rdata,
    output logic                      branch_valid,
    output logic [DW-1:0]             branch_pc,
    output logic                      ret_done,
    output logic [DW-1:0]             ret_pc,
    output logic [FRAME_WORDS*DW-1:0] rest_ctx,
    output logic [AW-1:0]             sp_out,
    output logic                      busy,
    output logic                      in_handler
);
    localparam int NW          = FRAME_WORDS;
    localparam int IDX_W       = $clog2(NW);
    localparam int STEP        = DW / 8;
    localparam int STEP_SH     = $clog2(STEP);
    localparam int FRAME_BYTES = NW * STEP;
    localparam int CNT_MAX     = (REFILL_CYC > TAIL_GAP) ? REFILL_CYC : TAIL_GAP;
    localparam int CNT_W       = $clog2(CNT_MAX + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
        logic [AW-1:0]    sp;
        logic [NUM_W-1:0] num;
        logic [DW-1:0]    hpc;
    } seq_regs_t;

    seq_regs_t d, q;
    logic      xfer;
    logic      pop_load;
    logic [DW-1:0] push_word;

    exc_word_sel #(.DW(DW), .NW(NW)) u_sel (
        .words_i (ctx_in),
        .sel_i   (q.idx),
        .word_o  (push_word)
    );

    exc_pop_store #(.DW(DW), .NW(NW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (pop_load),
        .sel_i   (q.idx),
        .din_i   (mem_rdata),
        .words_o (rest_ctx)
    );

    // Memory request and visible outputs decoded from the registered state
    always_comb begin
        mem_valid = (q.st == S_PUSH) || (q.st == S_VEC) || (q.st == S_POP);
        mem_we    = (q.st == S_PUSH);
        mem_wdata = (q.st == S_PUSH) ? push_word : '0;
        if (q.st == S_VEC) begin
            mem_addr = vec_base + (AW'(q.num) << STEP_SH);
        end else begin
            mem_addr = q.sp + (AW'(q.idx) << STEP_SH);
        end
    end

    assign xfer         = mem_valid && mem_ready;
    assign pop_load     = (q.st == S_POP) && mem_ready;
    assign branch_valid = (q.st == S_ENTER);
    assign branch_pc    = q.hpc;
    assign ret_done     = (q.st == S_DONE);
    assign ret_pc       = rest_ctx[PC_SLOT*DW +: DW];
    assign sp_out       = q.sp;
    assign busy         = (q.st != S_IDLE);
    assign in_handler   = (q.st == S_HANDLER);

    always_comb begin
        d = q;
        unique case (q.st)
            S_IDLE: begin
                if (entry_req) begin
                    d.st  = S_PUSH;
                    d.idx = IDX_W'(NW - 1);
                    d.sp  = sp_in - AW'(FRAME_BYTES);
                    d.num = entry_num;
                end
            end
            S_PUSH: begin
                if (xfer) begin
                    if (q.idx == '0) begin
                        d.st = S_VEC;
                    end else begin
                        d.idx = q.idx - 1'b1;
                    end
                end
            end
            S_VEC: begin
                if (xfer) begin
                    d.hpc = mem_rdata;
                    d.st  = S_REFILL;
                    d.cnt = '0;
                end
            end
            S_TAIL: begin
                if (q.cnt == CNT_W'(TAIL_GAP - 1)) begin
                    d.st = S_VEC;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_REFILL: begin
                if (q.cnt == CNT_W'(REFILL_CYC - 1)) begin
                    d.st = S_ENTER;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            S_ENTER: begin
                d.st = S_HANDLER;
            end
            S_HANDLER: begin
                if (ret_req) begin
                    if (pend_valid) begin
                        d.st  = S_TAIL;
                        d.cnt = '0;
                        d.num = pend_num;
                    end else begin
                        d.st  = S_POP;
                        d.idx = '0;
                    end
                end
            end
            S_POP: begin
                if (xfer) begin
                    if (q.idx == IDX_W'(NW - 1)) begin
                        d.st = S_DONE;
                        d.sp = q.sp + AW'(FRAME_BYTES);
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            S_DONE: begin
                d.st = S_IDLE;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    // R2: frame beats walk downward one word at a time
    p_push_desc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_PUSH && mem_ready && q.idx != '0)
        |=> (mem_addr == $past(mem_addr) - AW'(STEP)));

    // R7: restore beats walk upward one word at a time
    p_pop_asc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_POP && mem_ready && q.idx != IDX_W'(NW - 1))
        |=> (mem_addr == $past(mem_addr) + AW'(STEP)));

    // R5: a stalled request is held unchanged
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready)
        |=> (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    // R4: branch strobe lasts one cycle
    p_branch_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        branch_valid |=> !branch_valid);

    // R7: exit strobe lasts one cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ret_done |=> !ret_done);

    // R6: tail-chain leaves the stack pointer alone
    p_tail_sp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == S_TAIL) |=> $stable(sp_out));

    // R8: entry request during a handler does not disturb it
    p_ignore_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_handler && entry_req && !ret_req) |=> in_handler);
endmodule

// File: tb/exc_frame_seq_test.sv
`timescale 1ns/1ps
module exc_frame_seq_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         entry_req = 1'b0;
    logic [5:0]   entry_num = '0;
    logic [31:0]  sp_in = '0;
    logic [31:0]  vec_base = '0;
    logic [255:0] ctx_in = '0;
    logic         ret_req = 1'b0;
    logic         pend_valid = 1'b0;
    logic [5:0]   pend_num = '0;
    logic         mem_valid, mem_we, mem_ready;
    logic [31:0]  mem_addr, mem_wdata, mem_rdata;
    logic         branch_valid, ret_done, busy, in_handler;
    logic [31:0]  branch_pc, ret_pc, sp_out;
    logic [255:0] rest_ctx;

    always #2 clk = ~clk;

    exc_frame_seq uut (
        .clk(clk), .rst_n(rst_n), .entry_req(entry_req), .entry_num(entry_num),
        .sp_in(sp_in), .vec_base(vec_base), .ctx_in(ctx_in), .ret_req(ret_req),
        .pend_valid(pend_valid), .pend_num(pend_num), .mem_valid(mem_valid),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata), .branch_valid(branch_valid),
        .branch_pc(branch_pc), .ret_done(ret_done), .ret_pc(ret_pc),
        .rest_ctx(rest_ctx), .sp_out(sp_out), .busy(busy), .in_handler(in_handler)
    );

    // Memory model: vector table below 0x140 (bench-written), stack above
    logic [31:0] vmem [0:255];
    logic [31:0] smem [0:255];
    int          gen = 0;
    int          stall_total = 0;
    logic        stall_wr = 1'b0;

    int          seen_gen = 0;
    int          stalls_used = 0;
    int          n_log = 0;
    logic [31:0] log_addr [0:31];
    logic [31:0] log_data [0:31];
    logic        log_we   [0:31];
    int          cyc = 0, acc_cyc = 0, rt_cyc = 0, br_cyc = 0, dn_cyc = 0;
    logic [31:0] br_pc = '0, dn_pc = '0;

    assign mem_ready = !(mem_valid && (mem_we == stall_wr) && (stalls_used < stall_total));
    assign mem_rdata = (mem_addr < 32'h140) ? vmem[mem_addr[9:2]] : smem[mem_addr[9:2]];

    always @(posedge clk) begin
        if (rst_n) begin
            if (entry_req && !busy)   acc_cyc <= cyc;
            if (ret_req && in_handler) rt_cyc <= cyc;
            if (branch_valid) begin br_cyc <= cyc; br_pc <= branch_pc; end
            if (ret_done)     begin dn_cyc <= cyc; dn_pc <= ret_pc; end
            if (mem_valid && mem_ready) begin
                log_addr[n_log[4:0]] <= mem_addr;
                log_we[n_log[4:0]]   <= mem_we;
                log_data[n_log[4:0]] <= mem_we ? mem_wdata : mem_rdata;
                if (mem_we) smem[mem_addr[9:2]] <= mem_wdata;
                n_log <= n_log + 1;
            end else if (mem_valid) begin
                stalls_used <= stalls_used + 1;
            end
        end
        if (gen != seen_gen) begin
            seen_gen    <= gen;
            n_log       <= 0;
            stalls_used <= 0;
        end
        cyc <= cyc + 1;
    end

    typedef struct packed {
        logic [31:0] sp;
        logic [31:0] vb;
        logic [5:0]  num;
        logic [31:0] hnd;
        logic        tail;
        logic [5:0]  pnum;
        logic [31:0] phnd;
        logic [3:0]  stall;
        logic        stall_wr;
    } scen_t;

    localparam scen_t SCN [4] = '{
        '{32'h200, 32'h000, 6'd3,  32'h1001, 1'b0, 6'd0, 32'h0,    4'd0, 1'b0},
        '{32'h3F0, 32'h040, 6'd15, 32'h2A2B, 1'b1, 6'd2, 32'h3C3D, 4'd0, 1'b0},
        '{32'h180, 32'h100, 6'd0,  32'h0505, 1'b0, 6'd0, 32'h0,    4'd2, 1'b0},
        '{32'h2C0, 32'h080, 6'd7,  32'h7E7E, 1'b1, 6'd7, 32'h7E7E, 4'd1, 1'b1}
    };

    int n_chk = 0;
    int n_bad = 0;

    function automatic logic [31:0] ctxw(input logic [31:0] sp, input int k);
        return 32'hC0DE_0000 ^ (sp << 8) ^ (32'(k) * 32'h0101_0101);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_handler();
        for (int i = 0; i < 200 && !in_handler; i++) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    endtask

    task automatic do_entry(input logic [31:0] sp, input logic [31:0] vb,
                            input logic [5:0] num, input int stl, input logic swr);
        @(negedge clk);
        gen++;
        stall_total = stl;
        stall_wr    = swr;
        sp_in       = sp;
        vec_base    = vb;
        entry_num   = num;
        for (int k = 0; k < 8; k++) ctx_in[32*k +: 32] = ctxw(sp, k);
        entry_req = 1'b1;
        @(negedge clk);
        entry_req = 1'b0;
        wait_handler();
    endtask

    task automatic do_ret(input logic pend, input logic [5:0] pn, input int stl, input logic swr);
        @(negedge clk);
        gen++;
        stall_total = stl;
        stall_wr    = swr;
        pend_valid  = pend;
        pend_num    = pn;
        ret_req     = 1'b1;
        @(negedge clk);
        ret_req    = 1'b0;
        pend_valid = 1'b0;
        if (pend) wait_handler();
        else      wait_idle();
    endtask

    task automatic check_entry(input logic [31:0] sp, input logic [31:0] vb,
                               input logic [5:0] num, input logic [31:0] hnd, input int extra);
        chk("R2 beat count", 32'(n_log), 32'd9);
        for (int j = 0; j < 8; j++) begin
            chk("R2 push addr", log_addr[j], sp - 32'(4 * (j + 1)));
            chk("R2 push we", 32'(log_we[j]), 32'd1);
            chk("R2 push data", log_data[j], ctxw(sp, 7 - j));
        end
        chk("R3 vector addr", log_addr[8], vb + 32'(num) * 4);
        chk("R3 vector read", 32'(log_we[8]), 32'd0);
        chk(extra != 0 ? "R5 stalled entry latency" : "R4 entry latency",
            32'(br_cyc - acc_cyc - 1), 32'(12 + extra));
        chk("R4 branch pc", br_pc, hnd);
        chk("R2 sp after entry", sp_out, sp - 32'd32);
    endtask

    task automatic check_exit(input logic [31:0] sp, input int extra);
        chk("R7 beat count", 32'(n_log), 32'd8);
        for (int j = 0; j < 8; j++) begin
            chk("R7 pop addr", log_addr[j], sp - 32'd32 + 32'(4 * j));
            chk("R7 pop read", 32'(log_we[j]), 32'd0);
            chk("R7 restored word", rest_ctx[32*j +: 32], ctxw(sp, j));
        end
        chk("R7 return pc", dn_pc, ctxw(sp, 6));
        chk(extra != 0 ? "R5 stalled exit latency" : "R7 exit latency",
            32'(dn_cyc - rt_cyc - 1), 32'(8 + extra));
        chk("R7 sp after exit", sp_out, sp);
        chk("R7 idle after exit", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        $display("FAIL watchdog (all requirements) actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin vmem[i] = '0; smem[i] = '0; end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 mem_valid", 32'(mem_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after release", 32'(busy), 32'd0);
        chk("R1 in_handler", 32'(in_handler), 32'd0);
        chk("R1 branch_valid", 32'(branch_valid), 32'd0);
        chk("R1 ret_done", 32'(ret_done), 32'd0);
        chk("R1 sp_out", sp_out, 32'd0);

        for (int s = 0; s < 4; s++) begin
            scen_t c = SCN[s];
            vmem[(c.vb >> 2) + 32'(c.num)] = c.hnd;
            if (c.tail) vmem[(c.vb >> 2) + 32'(c.pnum)] = c.phnd;
            do_entry(c.sp, c.vb, c.num, int'(c.stall), c.stall_wr);
            check_entry(c.sp, c.vb, c.num, c.hnd, int'(c.stall));
            repeat (2) @(negedge clk);
            if (c.tail) begin
                do_ret(1'b1, c.pnum, int'(c.stall), c.stall_wr);
                chk("R6 tail beat count", 32'(n_log), 32'd1);
                chk("R6 tail vector addr", log_addr[0], c.vb + 32'(c.pnum) * 4);
                chk("R6 tail no write", 32'(log_we[0]), 32'd0);
                chk("R6 tail latency", 32'(br_cyc - rt_cyc - 1),
                    32'(6 + (c.stall_wr ? 0 : int'(c.stall))));
                chk("R6 tail branch pc", br_pc, c.phnd);
                chk("R6 tail sp unchanged", sp_out, c.sp - 32'd32);
                repeat (2) @(negedge clk);
            end
            do_ret(1'b0, 6'd0, int'(c.stall), c.stall_wr);
            check_exit(c.sp, c.stall_wr ? 0 : int'(c.stall));
        end

        // R8: return strobe while idle is ignored
        @(negedge clk);
        gen++;
        stall_total = 0;
        pend_valid = 1'b1;
        ret_req = 1'b1;
        @(negedge clk);
        ret_req = 1'b0;
        pend_valid = 1'b0;
        repeat (6) @(negedge clk);
        chk("R8 idle return busy", 32'(busy), 32'd0);
        chk("R8 idle return traffic", 32'(n_log), 32'd0);

        // R8: entry request while in a handler is ignored
        do_entry(32'h240, 32'h000, 6'd3, 0, 1'b0);
        check_entry(32'h240, 32'h000, 6'd3, 32'h1001, 0);
        @(negedge clk);
        gen++;
        entry_num = 6'd9;
        sp_in = 32'h100;
        entry_req = 1'b1;
        @(negedge clk);
        entry_req = 1'b0;
        repeat (20) @(negedge clk);
        chk("R8 busy entry traffic", 32'(n_log), 32'd0);
        chk("R8 still in handler", 32'(in_handler), 32'd1);
        chk("R8 sp kept", sp_out, 32'h220);
        sp_in = 32'h240;
        do_ret(1'b0, 6'd0, 0, 1'b0);
        check_exit(32'h240, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule